// File: doc/BRIEF.md
# I2C Slave Own-Address Matcher

This block decides, once per transfer, whether the address that follows a START condition on an I2C bus selects this slave. A bit-level receiver in front of it does the serial shifting. It passes in each completed address byte with a one-cycle strobe, along with single-cycle START and STOP indications. The block compares that byte against two own-address slots, which can be enabled together. The first slot holds either a 7-bit address or a 10-bit address. The second slot holds a 7-bit address, and a mask count can drop its low bits from the compare so that a group of addresses is answered.

For each transfer the block issues one decision pulse with an ACK verdict. It keeps a hit flag, and a flag naming the slot that hit, until the next START or STOP. Slot 1 wins when both slots accept the same address.

In low-power operation the block asks for its kernel clock as soon as START is seen. While that clock is not ready, it holds SCL low. A mismatch drops the request quietly. A match raises a wakeup and keeps SCL held until the system reports that it is awake. This path works only when clock stretching is allowed.

Top module: `i2c_addr_match`

## Requirements
- R1: With slot 1 enabled in 7-bit mode, an address byte is accepted when its bits 7..1 equal the low seven bits of the slot-1 address, whatever the value of bit 0 (R/W). The decision appears one cycle after the byte strobe as `addr_done`=1 together with `addr_ack`=1, `hit`=1 and `hit_slot2`=0.
- R2: With slot 1 in 10-bit mode, a 10-bit match needs two bytes. The first byte is binary 11110, then address bits 9 and 8, then a 0 (write) bit. It produces no decision. The second byte must equal address bits 7..0, and the decision is made one cycle after it. Any other first byte is rejected at once.
- R3: Slot 2 compares bits 7..1 of the byte with its 7-bit address. A mask value k from 0 to 7 leaves the k lowest of those bits out of the compare, and k=0 compares all seven bits. A match sets `hit_slot2`=1.
- R4: Both slots may be enabled at once, and a match on either slot gives an ACK. When both slots match, slot 1 is reported and `hit_slot2`=0.
- R5: A byte that no enabled slot accepts gives `addr_done`=1, `addr_ack`=0 and `hit`=0. A disabled slot never matches.
- R6: `hit` and `hit_slot2` keep their value until the next START or STOP, and both events clear them.
- R7: When low-power mode and stretching are both enabled, START raises `clk_req` on the next cycle. `scl_hold` is high while the address phase is open and `clk_ready` is low.
- R8: In low-power mode a mismatch drops `clk_req` in the decision cycle, never raises `wake_irq`, and releases SCL.
- R9: In low-power mode a match raises `wake_irq` in the decision cycle. SCL stays held, even with the clock ready, until `sys_awake` is seen, which clears both `wake_irq` and `clk_req` one cycle later.
- R10: With stretching disabled, low-power mode has no effect: no `clk_req`, no `wake_irq` and no `scl_hold`.
- R11: After the decision, further byte strobes are ignored until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_det | input | 1 | START (or repeated START) seen, one cycle |
| stop_det | input | 1 | STOP seen, one cycle; has priority over START |
| addr_byte | input | 8 | Received address byte, R/W in bit 0 |
| addr_vld | input | 1 | Strobe: `addr_byte` holds a new byte |
| slot1_en | input | 1 | Enable slot 1 |
| slot1_ten | input | 1 | Slot 1 uses 10-bit addressing |
| slot1_addr | input | 10 | Slot 1 address; only bits 6..0 are used in 7-bit mode |
| slot2_en | input | 1 | Enable slot 2 |
| slot2_addr | input | 7 | Slot 2 address |
| slot2_mask | input | 3 | Number of low slot-2 bits ignored |
| lp_mode | input | 1 | Low-power wakeup operation |
| stretch_en | input | 1 | Clock stretching allowed |
| clk_ready | input | 1 | Kernel clock is running |
| sys_awake | input | 1 | System has left its sleep state |
| addr_done | output | 1 | Decision pulse |
| addr_ack | output | 1 | ACK verdict, valid with `addr_done` |
| hit | output | 1 | Address matched in this transfer |
| hit_slot2 | output | 1 | The match came from slot 2 |
| clk_req | output | 1 | Kernel clock request |
| wake_irq | output | 1 | Wakeup interrupt |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The address phase is short, so a wrong phase register shows up quickly. A two-byte 10-bit header could decide after its first byte, or a stale decided state could accept a late byte. Either fault appears at `addr_done` and `hit` within one cycle of the offending strobe. A bad mask shift or a wrong slot priority changes `addr_ack` or `hit_slot2` for particular address values, so the bench sweeps every byte value for every mask setting. Faults in the low-power handshake show up on `clk_req`, `wake_irq` and `scl_hold` one cycle after START, after the decision or after `sys_awake`.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] addr_byte,
  input  logic       addr_vld,
  input  logic       slot1_en,
  input  logic       slot1_ten,
  input  logic [9:0] slot1_addr,
  input  logic       slot2_en,
  input  logic [6:0] slot2_addr,
  input  logic [2:0] slot2_mask,
  input  logic       lp_mode,
  input  logic       stretch_en,
  input  logic       clk_ready,
  input  logic       sys_awake,
  output logic       addr_done,
  output logic       addr_ack,
  output logic       hit,
  output logic       hit_slot2,
  output logic       clk_req,
  output logic       wake_irq,
  output logic       scl_hold
);
  localparam int AW = 7;
  localparam logic [4:0] TEN_HDR = 5'b11110;

  typedef enum logic [1:0] {PH_IDLE, PH_FIRST, PH_SECOND, PH_DONE} phase_t;
  phase_t ph;

  logic [AW-1:0] rx7, keep;
  logic lp_ok, s1_m7, s2_m7, hdr_ok, low_ok, open_ph;

  assign rx7     = addr_byte[7:1];
  assign keep    = {AW{1'b1}} << slot2_mask;
  assign lp_ok   = lp_mode && stretch_en;
  assign s1_m7   = slot1_en && !slot1_ten && (rx7 == slot1_addr[AW-1:0]);
  assign s2_m7   = slot2_en && (((rx7 ^ slot2_addr) & keep) == '0);
  assign hdr_ok  = slot1_en && slot1_ten && (addr_byte[7:3] == TEN_HDR)
                   && (addr_byte[2:1] == slot1_addr[9:8]) && !addr_byte[0];
  assign low_ok  = addr_byte == slot1_addr[7:0];
  assign open_ph = (ph == PH_FIRST) || (ph == PH_SECOND);
  assign scl_hold = (clk_req && !clk_ready && open_ph) || wake_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      addr_done <= 1'b0;
      addr_ack  <= 1'b0;
      hit       <= 1'b0;
      hit_slot2 <= 1'b0;
      clk_req   <= 1'b0;
      wake_irq  <= 1'b0;
    end else begin
      addr_done <= 1'b0;
      addr_ack  <= 1'b0;
      if (stop_det) begin
        ph        <= PH_IDLE;
        hit       <= 1'b0;
        hit_slot2 <= 1'b0;
        clk_req   <= 1'b0;
        wake_irq  <= 1'b0;
      end else if (start_det) begin
        ph        <= PH_FIRST;
        hit       <= 1'b0;
        hit_slot2 <= 1'b0;
        clk_req   <= lp_ok;
        wake_irq  <= 1'b0;
      end else begin
        if (sys_awake && wake_irq) begin
          wake_irq <= 1'b0;
          clk_req  <= 1'b0;
        end
        if (addr_vld && ph == PH_FIRST && !(s1_m7 || s2_m7) && hdr_ok) begin
          ph <= PH_SECOND;
        end else if (addr_vld && open_ph) begin
          ph        <= PH_DONE;
          addr_done <= 1'b1;
          if ((ph == PH_FIRST && (s1_m7 || s2_m7)) || (ph == PH_SECOND && low_ok)) begin
            addr_ack  <= 1'b1;
            hit       <= 1'b1;
            hit_slot2 <= (ph == PH_FIRST) && !s1_m7;
            wake_irq  <= clk_req;
          end else begin
            clk_req   <= 1'b0;
          end
        end
      end
    end
  end
endmodule

module i2c_addr_match_chk (
  input logic clk,
  input logic rst_n,
  input logic start_det,
  input logic stop_det,
  input logic lp_mode,
  input logic stretch_en,
  input logic addr_done,
  input logic addr_ack,
  input logic hit,
  input logic clk_req,
  input logic wake_irq,
  input logic scl_hold
);
  assert_ack_in_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack |-> addr_done);
  assert_ack_sets_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done |-> (addr_ack == hit));
  assert_hit_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !start_det && !stop_det |=> hit);
  assert_req_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_det && !stop_det && lp_mode && stretch_en |=> clk_req);
  assert_miss_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done && !addr_ack |-> !clk_req && !wake_irq);
  assert_wake_holds_scl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> scl_hold);
  assert_no_req_unstretched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det && !(lp_mode && stretch_en) |=> !clk_req);
endmodule

bind i2c_addr_match i2c_addr_match_chk chk (
  .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
  .lp_mode(lp_mode), .stretch_en(stretch_en), .addr_done(addr_done),
  .addr_ack(addr_ack), .hit(hit), .clk_req(clk_req), .wake_irq(wake_irq),
  .scl_hold(scl_hold)
);

// File: tb/i2c_addr_match_test.sv
module i2c_addr_match_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 0, rst_n = 0;
  logic start_det = 0, stop_det = 0, addr_vld = 0;
  logic [7:0] addr_byte = 0;
  logic slot1_en = 0, slot1_ten = 0, slot2_en = 0;
  logic [9:0] slot1_addr = 0;
  logic [6:0] slot2_addr = 0;
  logic [2:0] slot2_mask = 0;
  logic lp_mode = 0, stretch_en = 0, clk_ready = 0, sys_awake = 0;
  logic addr_done, addr_ack, hit, hit_slot2, clk_req, wake_irq, scl_hold;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_match uut (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp=finish", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    start_det = 1; @(negedge clk); start_det = 0;
  endtask

  task automatic do_stop();
    stop_det = 1; @(negedge clk); stop_det = 0;
  endtask

  task automatic send(input logic [7:0] b);
    addr_byte = b; addr_vld = 1; @(negedge clk); addr_vld = 0;
  endtask

  task automatic expect_decision(input string req, input bit ack, input bit s2);
    check({req, " done"}, addr_done, 1);
    check({req, " ack"}, addr_ack, ack);
    check({req, " hit"}, hit, ack);
    check({req, " slot2"}, hit_slot2, s2);
  endtask

  function automatic bit m7(input logic [6:0] a, input logic [6:0] b, input int k);
    return (a >> k) == (b >> k);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset hit", hit, 0);
    check("R7 reset clk_req", clk_req, 0);
    check("R9 reset wake", wake_irq, 0);
    check("R7 reset hold", scl_hold, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 slot 1 7-bit, every byte
    slot1_en = 1; slot1_addr = 10'h02A;
    for (int b = 0; b < 256; b++) begin
      do_start();
      send(8'(b));
      expect_decision("R1", (b >> 1) == 'h2A, 0);
    end

    // R3 slot 2 alone with every mask value
    slot1_en = 0; slot2_en = 1; slot2_addr = 7'h55;
    for (int k = 0; k < 8; k++) begin
      slot2_mask = 3'(k);
      for (int b = 0; b < 256; b++) begin
        bit e;
        e = m7(7'(b >> 1), 7'h55, k);
        do_start();
        send(8'(b));
        expect_decision("R3", e, e);
      end
    end

    // R4 both slots, overlapping group
    slot1_en = 1; slot1_addr = 10'h054; slot2_mask = 3'd2;
    for (int b = 0; b < 256; b++) begin
      bit e1, e2;
      e1 = (b >> 1) == 'h54;
      e2 = m7(7'(b >> 1), 7'h55, 2);
      do_start();
      send(8'(b));
      expect_decision("R4", e1 || e2, e2 && !e1);
    end

    // R5 disabled slots never match
    slot1_en = 0; slot2_en = 0;
    for (int b = 0; b < 256; b += 5) begin
      do_start();
      send(8'(b));
      expect_decision("R5", 0, 0);
    end

    // R2 10-bit: sweep first byte, then second byte for the valid header
    slot1_en = 1; slot1_ten = 1; slot1_addr = 10'h2B7;
    for (int b = 0; b < 256; b++) begin
      do_start();
      send(8'(b));
      if (b == 'hF4) begin
        check("R2 header no done", addr_done, 0);
        send(8'hB7);
        expect_decision("R2 second", 1, 0);
      end else begin
        expect_decision("R2 bad first", 0, 0);
      end
    end
    for (int lo = 0; lo < 256; lo++) begin
      do_start();
      send(8'hF4);
      send(8'(lo));
      expect_decision("R2 low", lo == 'hB7, 0);
    end

    // R11 late bytes ignored, R6 hold and clears
    slot1_ten = 0; slot1_addr = 10'h02A;
    do_start(); send(8'h12);
    expect_decision("R11 miss", 0, 0);
    send(8'h54);
    check("R11 late byte done", addr_done, 0);
    check("R11 late byte hit", hit, 0);
    do_start(); send(8'h55);
    expect_decision("R6 match", 1, 0);
    repeat (4) @(negedge clk);
    check("R6 held", hit, 1);
    send(8'h00);
    check("R11 after hit", hit, 1);
    do_stop();
    check("R6 stop clears", hit, 0);
    do_start(); send(8'h54);
    do_start();
    check("R6 start clears", hit, 0);

    // R7/R8 low-power miss
    lp_mode = 1; stretch_en = 1; clk_ready = 0;
    do_stop();
    do_start();
    check("R7 clk_req", clk_req, 1);
    check("R7 hold", scl_hold, 1);
    repeat (3) @(negedge clk);
    check("R7 hold waits", scl_hold, 1);
    clk_ready = 1; #1;
    check("R7 release", scl_hold, 0);
    @(negedge clk);
    send(8'h10);
    expect_decision("R8 miss", 0, 0);
    check("R8 clk_req", clk_req, 0);
    check("R8 wake", wake_irq, 0);
    check("R8 hold", scl_hold, 0);

    // R9 low-power match
    clk_ready = 0;
    do_start();
    check("R9 clk_req", clk_req, 1);
    clk_ready = 1;
    @(negedge clk);
    send(8'h55);
    expect_decision("R9 match", 1, 0);
    check("R9 wake", wake_irq, 1);
    check("R9 hold", scl_hold, 1);
    repeat (3) @(negedge clk);
    check("R9 hold stays", scl_hold, 1);
    sys_awake = 1;
    @(negedge clk);
    sys_awake = 0;
    check("R9 wake cleared", wake_irq, 0);
    check("R9 req cleared", clk_req, 0);
    check("R9 hold cleared", scl_hold, 0);
    check("R9 hit kept", hit, 1);

    // R10 stretching disabled
    stretch_en = 0; clk_ready = 0;
    do_start();
    check("R10 clk_req", clk_req, 0);
    check("R10 hold", scl_hold, 0);
    send(8'h55);
    expect_decision("R10 match", 1, 0);
    check("R10 wake", wake_irq, 0);
    check("R10 hold after", scl_hold, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule